// File: doc/BRIEF.md
# Amplifier Control Register Slave (Two-Wire, Write-Only)

This block is the control-register front end of an audio power amplifier. It watches a two-wire I2C bus (serial clock and open-drain serial data) from inside a faster system-clock domain. It recognises bus START and STOP conditions and answers only to its own fixed 7-bit address with a write request. After a matching address it accepts any number of data bytes until STOP. Each data byte carries its own register select in its most significant bit, so no register-address byte is sent.

Two registers are held. The mode register carries a run/shutdown bit, a mute bit and a test flag. The volume register carries a 6-bit volume code. The block presents the stored values on its outputs, together with an effective gain code that reads as the mute level while mute is set. The active-low reset clears both registers and makes the block deaf to the bus, which leaves the amplifier in shutdown at the mute level until software writes it again. The block never drives the data line high; it only asserts a pull-low enable during acknowledge clocks.

Top module: `amp_ctl_i2c`

## Requirements
- R1: While rst_n is low (sampled at clk), vol_code_o is 0, run_o, mute_o and test_o are 0, sda_pull_o is 0 and bus traffic is neither acknowledged nor applied; after release the outputs keep these values until a write arrives.
- R2: A START followed by the address byte 1101111 (sent MSB first) with R/W = 0 as the eighth bit is acknowledged by sda_pull_o being high while SCL is high in the ninth clock; an address differing in any bit is not acknowledged.
- R3: An address byte with the matching address but R/W = 1 is not acknowledged, and data bytes that follow it up to the next START are neither acknowledged nor applied.
- R4: An acknowledged data byte with bit 7 = 1 loads bits 5:0 into vol_code_o; bit 6 is ignored and the mode outputs are unchanged.
- R5: An acknowledged data byte with bit 7 = 0 loads bit 0 into run_o (1 = run, 0 = shutdown), bit 1 into mute_o and bit 4 into test_o; bits 2, 3, 5 and 6 are ignored and vol_code_o is unchanged.
- R6: gain_code_o equals 0 while mute_o is 1 and equals vol_code_o otherwise; clearing mute restores the stored volume.
- R7: Writing run_o to 0 keeps vol_code_o; setting run_o back to 1 shows the earlier volume again.
- R8: Any number of data bytes after one matching address are each acknowledged and applied in order, each to the register named by its own bit 7.
- R9: After STOP, bytes clocked without a new START and matching address are not acknowledged and leave all register outputs unchanged.
- R10: A START inside a transfer abandons the partially received byte and returns the block to the address phase.
- R11: sda_pull_o only changes while SCL is low and is released after the ninth clock of every byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; clears registers and blocks the bus |
| scl_i | input | 1 | Serial clock from the bus master |
| sda_i | input | 1 | Serial data as seen on the wired bus line |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| vol_code_o | output | 6 | Stored volume code |
| run_o | output | 1 | 1 = amplifier running, 0 = shutdown |
| mute_o | output | 1 | 1 = muted |
| test_o | output | 1 | Stored test flag |
| gain_code_o | output | 6 | Effective gain code, 0 while muted |

## Verification
The bench sweeps all 64 volume codes, with the ignored bit 6 toggling, and all 128 mode payloads, so a design that mixed up a field position or let an ignored bit through shows a wrong output at once. Every single-bit corruption of the address and the read request are sent to catch a slave that decodes the address loosely or acknowledges reads. A byte stream clocked after STOP without a new address, a START cut into the middle of a data byte, and a reset asserted mid-transfer target a block that keeps listening too long, completes a half byte, or writes while held in reset. Mute and shutdown are toggled over a fixed volume to catch a design that destroys the stored code instead of overriding it.

// File: rtl/amp_ctl_pkg.sv
// Shared definitions for the amplifier control slave.
// Assumes byte-oriented bus framing with one acknowledge clock per byte.
package amp_ctl_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_DATA,
        ST_SKIP
    } bus_state_t;
endpackage

// File: rtl/amp_line_sync.sv
// Brings one bus line into the clk domain through STAGES flops and keeps
// one extra flop of history for edge detection.
// Assumes the idle bus level is high, so reset loads ones.
module amp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic prev_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] pipe;

    // Shift the raw line through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], line_i};
    end

    assign level_o = pipe[STAGES-1];
    assign prev_o  = pipe[STAGES];
    assign rise_o  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall_o  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/amp_bus_engine.sv
// Protocol engine: detects START/STOP, shifts bits on SCL rising edges,
// matches the device address with a write request, drives acknowledge
// clocks and emits a one-cycle write strobe per completed data byte.
// Assumes synchronized line levels and edges of equal latency.
module amp_bus_engine
    import amp_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_prev,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_prev,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_byte_o,
    output logic              pull_o
);
    localparam int                CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0] WR_REQ   = {DEV_ADDR, 1'b0};

    bus_state_t        st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] sh;
    logic              pull;
    logic              start_det;
    logic              stop_det;
    logic              last_bit;
    logic [BYTE_W-1:0] rx_byte;

    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    assign rx_byte   = {sh, sda_lvl};
    assign last_bit  = scl_rise && (cnt == LAST_BIT);
    assign wr_en_o   = (st == ST_DATA) && last_bit;
    assign wr_byte_o = rx_byte;
    assign pull_o    = pull;

    // Frame tracking, bit counting and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            sh   <= '0;
            pull <= 1'b0;
        end else if (start_det) begin
            st   <= ST_ADDR;
            cnt  <= '0;
            pull <= 1'b0;
        end else if (stop_det) begin
            st   <= ST_IDLE;
            pull <= 1'b0;
        end else begin
            case (st)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise) begin
                        sh  <= rx_byte[BYTE_W-2:0];
                        cnt <= last_bit ? '0 : cnt + 1'b1;
                        if (last_bit) begin
                            if (st == ST_DATA || rx_byte == WR_REQ) st <= ST_ACK;
                            else                                    st <= ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        pull <= ~pull;
                        if (pull) st <= ST_DATA;
                    end
                end
                default: st <= st;
            endcase
        end
    end
endmodule

// File: rtl/amp_reg_bank.sv
// Mode and volume registers written by data bytes whose top bit selects
// the target; produces the mute-aware effective gain code.
// Assumes one write strobe per accepted byte.
module amp_reg_bank
    import amp_ctl_pkg::*;
#(
    parameter int VOL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [VOL_W-1:0]  vol_o,
    output logic              run_o,
    output logic              mute_o,
    output logic              test_o,
    output logic [VOL_W-1:0]  gain_o
);
    localparam int SEL_BIT  = BYTE_W - 1;
    localparam int RUN_BIT  = 0;
    localparam int MUTE_BIT = 1;
    localparam int TEST_BIT = 4;

    // Register update on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_o  <= '0;
            run_o  <= 1'b0;
            mute_o <= 1'b0;
            test_o <= 1'b0;
        end else if (wr_en) begin
            if (wr_byte[SEL_BIT]) begin
                vol_o <= wr_byte[VOL_W-1:0];
            end else begin
                run_o  <= wr_byte[RUN_BIT];
                mute_o <= wr_byte[MUTE_BIT];
                test_o <= wr_byte[TEST_BIT];
            end
        end
    end

    // Mute overrides the output gain without touching the stored volume.
    always_comb begin
        gain_o = mute_o ? '0 : vol_o;
    end
endmodule

// File: rtl/amp_ctl_i2c.sv
// Top level of the write-only amplifier control slave: two line
// synchronizers, the protocol engine and the register bank.
// Assumes SCL runs well below clk / (2 * (SYNC_STAGES + 2)).
module amp_ctl_i2c #(
    parameter logic [6:0] DEV_ADDR    = 7'h6F,
    parameter int         SYNC_STAGES = 2,
    parameter int         VOL_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    output logic [VOL_W-1:0] vol_code_o,
    output logic             run_o,
    output logic             mute_o,
    output logic             test_o,
    output logic [VOL_W-1:0] gain_code_o
);
    logic       scl_s, scl_p, scl_rise, scl_fall;
    logic       sda_s, sda_p, sda_rise, sda_fall;
    logic       wr_en;
    logic [7:0] wr_byte;

    amp_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_s), .prev_o(scl_p), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    amp_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_s), .prev_o(sda_p), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    amp_bus_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_s), .scl_prev(scl_p), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_s), .sda_prev(sda_p),
        .wr_en_o(wr_en), .wr_byte_o(wr_byte), .pull_o(sda_pull_o)
    );

    amp_reg_bank #(.VOL_W(VOL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
        .vol_o(vol_code_o), .run_o(run_o), .mute_o(mute_o), .test_o(test_o),
        .gain_o(gain_code_o)
    );

    logic unused_edges;
    assign unused_edges = sda_rise ^ sda_fall;
endmodule

// File: rtl/amp_ctl_i2c_chk.sv
// Property checker for amp_ctl_i2c, attached with bind below.
module amp_ctl_i2c_chk #(
    parameter int VOL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             scl_fall,
    input logic             wr_en,
    input logic [7:0]       wr_byte,
    input logic             sda_pull_o,
    input logic [VOL_W-1:0] vol_code_o,
    input logic             run_o,
    input logic             mute_o,
    input logic             test_o,
    input logic [VOL_W-1:0] gain_code_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vol_code_o == '0 && !run_o && !mute_o && !test_o && !sda_pull_o)); // R1
    AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall)); // R2
    AST_VOL_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte[7]) |=> $stable({run_o, mute_o, test_o})); // R4
    AST_MODE_KEEPS_VOL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte[7]) |=> $stable(vol_code_o)); // R5
    AST_UNMUTE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mute_o) && $stable(vol_code_o)) |-> (gain_code_o == vol_code_o)); // R6
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({vol_code_o, run_o, mute_o, test_o})); // R9
    AST_PULL_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull_o)); // R11
endmodule

bind amp_ctl_i2c amp_ctl_i2c_chk #(.VOL_W(VOL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
    .wr_en(wr_en), .wr_byte(wr_byte), .sda_pull_o(sda_pull_o),
    .vol_code_o(vol_code_o), .run_o(run_o), .mute_o(mute_o),
    .test_o(test_o), .gain_code_o(gain_code_o)
);

// File: tb/amp_ctl_i2c_bench.sv
`timescale 1ns/1ps
module amp_ctl_i2c_bench;
    localparam int HP = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [5:0] vol, gain;
    logic run, mute, test;
    logic sda_line;
    assign sda_line = sda_m & ~sda_pull;

    amp_ctl_i2c u_amp_ctl_i2c (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .vol_code_o(vol), .run_o(run), .mute_o(mute),
        .test_o(test), .gain_code_o(gain)
    );

    int nvec = 0;
    int nbad = 0;
    int e_vol = 0, e_run = 0, e_mute = 0, e_test = 0;
    logic ackv;

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk({req, " volume"}, int'(vol), e_vol);
        chk({req, " run"}, int'(run), e_run);
        chk({req, " mute"}, int'(mute), e_mute);
        chk({req, " test"}, int'(test), e_test);
        chk({req, " gain"}, int'(gain), (e_mute != 0) ? 0 : e_vol);
        chk({req, " pull idle"}, int'(sda_pull), 0);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(HP);
        scl_m = 1'b1; wt(HP);
        sda_m = 1'b0; wt(HP);
        scl_m = 1'b0; wt(HP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(HP);
        scl_m = 1'b1; wt(HP);
        sda_m = 1'b1; wt(HP);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wt(HP);
            scl_m = 1'b1; wt(HP);
            scl_m = 1'b0; wt(2);
        end
    endtask

    // Sends a byte and samples the acknowledge in the middle of clock nine.
    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wt(HP);
        scl_m = 1'b1; wt(HP / 2);
        ack = sda_pull;
        wt(HP / 2);
        scl_m = 1'b0; wt(HP / 2);
        chk("R11 released after ninth clock", int'(sda_pull), 0);
    endtask

    task automatic xfer(input string req, input logic [7:0] ab, input int n,
                        input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, input int exp_ack);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(ab, a);
        chk({req, " address ack"}, int'(a), exp_ack);
        for (int k = 0; k < n; k++) begin
            d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            send_byte(d, a);
            chk({req, " data ack"}, int'(a), exp_ack);
        end
        bus_stop();
        wt(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        wt(5);
        chk_regs("R1 during reset");
        rst_n = 1'b1;
        wt(5);
        chk_regs("R1 after release");

        // Full volume sweep with the ignored bit 6 alternating.
        for (int v = 0; v < 64; v++) begin
            xfer("R4 volume", 8'hDE, 1, 8'h80 | ((v % 2 == 1) ? 8'h40 : 8'h00) | 8'(v),
                 8'h00, 8'h00, 1);
            e_vol = v;
            chk_regs("R4 volume sweep");
        end

        xfer("R4 volume", 8'hDE, 1, 8'hA5, 8'h00, 8'h00, 1);
        e_vol = 37;
        // Every mode payload over a fixed volume.
        for (int m = 0; m < 128; m++) begin
            xfer("R5 mode", 8'hDE, 1, 8'(m), 8'h00, 8'h00, 1);
            e_run = m % 2;
            e_mute = (m / 2) % 2;
            e_test = (m / 16) % 2;
            chk_regs("R5 R6 mode sweep");
        end

        // Shutdown keeps the volume.
        xfer("R7 run", 8'hDE, 2, 8'h01, 8'hAC, 8'h00, 1);
        e_run = 1; e_mute = 0; e_test = 0; e_vol = 44;
        chk_regs("R7 running");
        xfer("R7 shutdown", 8'hDE, 1, 8'h00, 8'h00, 8'h00, 1);
        e_run = 0;
        chk_regs("R7 shutdown keeps volume");
        xfer("R7 rerun", 8'hDE, 1, 8'h01, 8'h00, 8'h00, 1);
        e_run = 1;
        chk_regs("R7 volume back after rerun");

        // Three bytes in one transfer, then unmute.
        xfer("R8 stream", 8'hDE, 3, 8'h95, 8'h03, 8'hAA, 1);
        e_vol = 42; e_run = 1; e_mute = 1;
        chk_regs("R8 stream applied in order");
        xfer("R6 unmute", 8'hDE, 1, 8'h01, 8'h00, 8'h00, 1);
        e_mute = 0;
        chk_regs("R6 unmute restores volume");

        // Every single-bit address corruption.
        for (int i = 0; i < 7; i++) begin
            xfer("R2 wrong address", {7'h6F ^ 7'(1 << i), 1'b0}, 1, 8'h81, 8'h00, 8'h00, 0);
            chk_regs("R2 wrong address ignored");
        end

        xfer("R3 read request", 8'hDF, 2, 8'h83, 8'h10, 8'h00, 0);
        chk_regs("R3 read request ignored");

        // Bytes after STOP without a new address.
        xfer("R9 setup", 8'hDE, 1, 8'h91, 8'h00, 8'h00, 1);
        e_vol = 17;
        send_byte(8'hDE, ackv);
        chk("R9 address without start ack", int'(ackv), 0);
        send_byte(8'h83, ackv);
        chk("R9 data without start ack", int'(ackv), 0);
        sda_m = 1'b1; wt(HP);
        scl_m = 1'b1; wt(HP);
        chk_regs("R9 bus ignored after stop");

        // Repeated START in the middle of a data byte.
        bus_start();
        send_byte(8'hDE, ackv);
        chk("R10 first address ack", int'(ackv), 1);
        send_bits(8'hBF, 4);
        bus_start();
        send_byte(8'hDE, ackv);
        chk("R10 second address ack", int'(ackv), 1);
        send_byte(8'h85, ackv);
        chk("R10 data ack", int'(ackv), 1);
        bus_stop();
        wt(4);
        e_vol = 5;
        chk_regs("R10 partial byte dropped");

        // Reset asserted mid-transfer, bus kept busy during reset.
        bus_start();
        send_byte(8'hDE, ackv);
        chk("R1 pre-reset ack", int'(ackv), 1);
        rst_n = 1'b0;
        send_byte(8'hBF, ackv);
        chk("R1 ack during reset", int'(ackv), 0);
        bus_stop();
        e_vol = 0; e_run = 0; e_mute = 0; e_test = 0;
        chk_regs("R1 reset clears");
        xfer("R1 traffic in reset", 8'hDE, 2, 8'hBF, 8'h13, 8'h00, 0);
        chk_regs("R1 traffic ignored in reset");
        rst_n = 1'b1;
        wt(10);
        chk_regs("R1 shutdown after release");
        xfer("R1 first write", 8'hDE, 1, 8'h81, 8'h00, 8'h00, 1);
        e_vol = 1;
        chk_regs("R1 writable after release");

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule